// File: doc/BRIEF.md
# Per-Core Wake and Start-Up Status Keeper

This block keeps the power status of every core in a small cluster and reacts to wake requests, standby notices, wake-enable writes, start-up and power-off commands. All of these arrive on a single command channel that carries an operation code, a core index and one argument bit. Each core has its own pending-wake flag, wake-enable bit, powered flag, standby flag and a two-bit wake-reason field.

When an interrupt controller raises a wake request for a core that is off and whose wake-enable bit is set, the block marks the core powered, records the interrupt-wake reason, pulses that core's reset for one cycle and answers with an acknowledge in the same cycle. A request that cannot power the core still leaves a pending mark and gets no acknowledge. Start-up commands clear the standby and pending flags and pulse the core reset.

Top module: `core_wake_ctrl`

## Requirements
- R1: After reset every core reads powered 0, pending 0, standby 0, wake-enable 0 and reason 2'b00, and neither acknowledge nor any core reset is active.
- R2: A wake-set command (op 3'd0) always sets the addressed core's pending flag.
- R3: A wake-set command for a core that is off and has wake-enable 1 sets powered, sets the reason to 2'b01, and raises the acknowledge and that core's reset bit for exactly the cycle after the command.
- R4: The acknowledge is raised only for a wake-set that powered a core; a wake-set to a core with wake-enable 0 or already powered gives no acknowledge and no core reset.
- R5: A wake-clear command (op 3'd1) clears the addressed core's pending flag.
- R6: A wake-set to a core that is already powered leaves its reason field unchanged.
- R7: A start-up command (op 3'd5) clears standby and pending, sets powered, pulses the core reset for one cycle, and writes reason 2'b00 when the argument is 0 or 2'b10 when it is 1.
- R8: Standby-set (op 3'd2) and standby-clear (op 3'd3) set and clear the standby flag; wake-enable write (op 3'd4) loads the argument into the wake-enable bit.
- R9: A power-off command (op 3'd6) clears only the powered flag of the addressed core.
- R10: A command changes only the core named by its core index; op 3'd7 and cycles with the valid input low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_cid | input | CID_W | Core index |
| cmd_arg | input | 1 | Argument bit (wake-enable value or start-up kind) |
| wake_ack | output | 1 | Wake request powered a core |
| core_rst | output | NUM_CORES | One-cycle reset pulse per core |
| powered | output | NUM_CORES | Core powered flags |
| wake_pend | output | NUM_CORES | Pending-wake flags |
| standby | output | NUM_CORES | Standby-for-interrupt flags |
| wake_en | output | NUM_CORES | Wake-enable bits |
| wake_reason | output | 2*NUM_CORES | Reason field, core n in bits [2n+1:2n] |

## Verification
Every result of a command is registered once, so each flag, the reason field, the acknowledge and the core reset are due at the clock edge that samples the command and no later. The bench drives a command on a falling edge, lets one rising edge pass and compares on the following falling edge, which is also the only window in which the acknowledge and reset pulses are visible. A pulse-width check then looks again one cycle later with the channel idle to confirm both pulses have dropped.

// File: rtl/cwc_pkg.sv
package cwc_pkg;
   typedef enum logic [2:0] {
      OP_WAKE_SET = 3'd0,
      OP_WAKE_CLR = 3'd1,
      OP_SBY_SET  = 3'd2,
      OP_SBY_CLR  = 3'd3,
      OP_WEN_WR   = 3'd4,
      OP_START    = 3'd5,
      OP_PWR_OFF  = 3'd6,
      OP_NONE     = 3'd7
   } cwc_op_e;

   localparam int REASON_W = 2;
   localparam logic [REASON_W-1:0] RSN_COLD  = 2'b00;
   localparam logic [REASON_W-1:0] RSN_IRQWK = 2'b01;
   localparam logic [REASON_W-1:0] RSN_PONRQ = 2'b10;

   typedef struct packed {
      logic wk_set;
      logic wk_clr;
      logic sby_set;
      logic sby_clr;
      logic wen_wr;
      logic start;
      logic pwr_off;
   } cwc_strobe_t;
endpackage

// File: rtl/cwc_decode.sv
module cwc_decode
   import cwc_pkg::*;
#(
   parameter int NUM_CORES = 4,
   localparam int CID_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                cmd_valid,
   input  logic [2:0]          cmd_op,
   input  logic [CID_W-1:0]    cmd_cid,
   output cwc_strobe_t         strb [NUM_CORES]
);
   cwc_strobe_t op_strb;

   always_comb begin
      op_strb = '0;
      if (cmd_valid) begin
         unique case (cwc_op_e'(cmd_op))
            OP_WAKE_SET: op_strb.wk_set  = 1'b1;
            OP_WAKE_CLR: op_strb.wk_clr  = 1'b1;
            OP_SBY_SET:  op_strb.sby_set = 1'b1;
            OP_SBY_CLR:  op_strb.sby_clr = 1'b1;
            OP_WEN_WR:   op_strb.wen_wr  = 1'b1;
            OP_START:    op_strb.start   = 1'b1;
            OP_PWR_OFF:  op_strb.pwr_off = 1'b1;
            default:     op_strb = '0;
         endcase
      end
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_sel
      always_comb begin
         strb[c] = (32'(cmd_cid) == c) ? op_strb : '0;
      end
   end
endmodule

// File: rtl/cwc_core_slot.sv
module cwc_core_slot
   import cwc_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  cwc_strobe_t          strb,
   input  logic                 arg,
   output logic                 ack_o,
   output logic                 rst_o,
   output logic                 powered_o,
   output logic                 pend_o,
   output logic                 sby_o,
   output logic                 wen_o,
   output logic [REASON_W-1:0]  reason_o
);
   logic wake_on;
   assign wake_on = strb.wk_set && !powered_o && wen_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_o     <= 1'b0;
         rst_o     <= 1'b0;
         powered_o <= 1'b0;
         pend_o    <= 1'b0;
         sby_o     <= 1'b0;
         wen_o     <= 1'b0;
         reason_o  <= RSN_COLD;
      end else begin
         ack_o <= wake_on;
         rst_o <= wake_on || strb.start;
         if (strb.wk_set) pend_o <= 1'b1;
         if (strb.wk_clr) pend_o <= 1'b0;
         if (strb.sby_set) sby_o <= 1'b1;
         if (strb.sby_clr) sby_o <= 1'b0;
         if (strb.wen_wr) wen_o <= arg;
         if (wake_on) begin
            powered_o <= 1'b1;
            reason_o  <= RSN_IRQWK;
         end
         if (strb.start) begin
            powered_o <= 1'b1;
            pend_o    <= 1'b0;
            sby_o     <= 1'b0;
            reason_o  <= arg ? RSN_PONRQ : RSN_COLD;
         end
         if (strb.pwr_off) powered_o <= 1'b0;
      end
   end

   a_r2_wake_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
      strb.wk_set |=> pend_o);
   a_r5_clear_drops_pending: assert property (@(posedge clk) disable iff (!rst_n)
      strb.wk_clr |=> !pend_o);
   a_r4_ack_needs_off_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.wk_set && (powered_o || !wen_o)) |=> !ack_o);
   a_r6_powered_keeps_reason: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.wk_set && powered_o) |=> $stable(reason_o));
   a_r3_reset_with_power: assert property (@(posedge clk) disable iff (!rst_n)
      rst_o |-> powered_o);
   a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      strb.start |=> (!sby_o && !pend_o && powered_o));
endmodule

// File: rtl/cwc_merge.sv
module cwc_merge #(
   parameter int NUM_CORES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CORES-1:0] ack_vec,
   output logic                 ack_any
);
   assign ack_any = |ack_vec;

   a_r4_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_vec));
endmodule

// File: rtl/core_wake_ctrl.sv
module core_wake_ctrl
   import cwc_pkg::*;
#(
   parameter int NUM_CORES = 4,
   localparam int CID_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_valid,
   input  logic [2:0]                  cmd_op,
   input  logic [CID_W-1:0]            cmd_cid,
   input  logic                        cmd_arg,
   output logic                        wake_ack,
   output logic [NUM_CORES-1:0]        core_rst,
   output logic [NUM_CORES-1:0]        powered,
   output logic [NUM_CORES-1:0]        wake_pend,
   output logic [NUM_CORES-1:0]        standby,
   output logic [NUM_CORES-1:0]        wake_en,
   output logic [2*NUM_CORES-1:0]      wake_reason
);
   if (NUM_CORES < 1 || NUM_CORES > 64) begin : g_bad_cores
      $error("core_wake_ctrl: NUM_CORES out of range");
   end
   if (REASON_W != 2) begin : g_bad_reason
      $error("core_wake_ctrl: reason width must be 2");
   end

   cwc_strobe_t            strb [NUM_CORES];
   logic [NUM_CORES-1:0]   ack_vec;

   cwc_decode #(.NUM_CORES(NUM_CORES)) u_dec (
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_cid   (cmd_cid),
      .strb      (strb)
   );

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      cwc_core_slot u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .strb      (strb[c]),
         .arg       (cmd_arg),
         .ack_o     (ack_vec[c]),
         .rst_o     (core_rst[c]),
         .powered_o (powered[c]),
         .pend_o    (wake_pend[c]),
         .sby_o     (standby[c]),
         .wen_o     (wake_en[c]),
         .reason_o  (wake_reason[2*c +: 2])
      );
   end

   cwc_merge #(.NUM_CORES(NUM_CORES)) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack_vec (ack_vec),
      .ack_any (wake_ack)
   );

   a_r10_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> (!wake_ack && core_rst == '0));
endmodule

// File: tb/sim_core_wake_ctrl.sv
module sim_core_wake_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = 3'd7;
   logic [1:0] cmd_cid = 2'd0;
   logic cmd_arg = 1'b0;
   logic wake_ack;
   logic [3:0] core_rst, powered, wake_pend, standby, wake_en;
   logic [7:0] wake_reason;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   core_wake_ctrl #(.NUM_CORES(4)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_cid(cmd_cid), .cmd_arg(cmd_arg), .wake_ack(wake_ack),
      .core_rst(core_rst), .powered(powered), .wake_pend(wake_pend),
      .standby(standby), .wake_en(wake_en), .wake_reason(wake_reason)
   );

   // {op, cid, arg, ack, rst[3:0], powered[3:0], pend[3:0]}
   localparam int NV = 13;
   localparam logic [18:0] VEC [NV] = '{
      {3'd4, 2'd0, 1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R8 wen c0
      {3'd0, 2'd1, 1'b0, 1'b0, 4'b0000, 4'b0000, 4'b0010}, // R2 R4 wen 0
      {3'd0, 2'd0, 1'b0, 1'b1, 4'b0001, 4'b0001, 4'b0011}, // R3 power on
      {3'd0, 2'd0, 1'b0, 1'b0, 4'b0000, 4'b0001, 4'b0011}, // R4 already on
      {3'd1, 2'd1, 1'b0, 1'b0, 4'b0000, 4'b0001, 4'b0001}, // R5
      {3'd5, 2'd2, 1'b0, 1'b0, 4'b0100, 4'b0101, 4'b0001}, // R7 cold start
      {3'd0, 2'd2, 1'b0, 1'b0, 4'b0000, 4'b0101, 4'b0101}, // R6
      {3'd5, 2'd2, 1'b1, 1'b0, 4'b0100, 4'b0101, 4'b0001}, // R7 clears pend
      {3'd6, 2'd0, 1'b0, 1'b0, 4'b0000, 4'b0100, 4'b0001}, // R9
      {3'd0, 2'd0, 1'b0, 1'b1, 4'b0001, 4'b0101, 4'b0001}, // R3 rewake
      {3'd7, 2'd1, 1'b0, 1'b0, 4'b0000, 4'b0101, 4'b0001}, // R10 op 7
      {3'd6, 2'd3, 1'b0, 1'b0, 4'b0000, 4'b0101, 4'b0001}, // R9 R10
      {3'd1, 2'd0, 1'b0, 1'b0, 4'b0000, 4'b0101, 4'b0000}  // R5
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cmd(input logic v, input logic [2:0] op, input logic [1:0] cid, input logic a);
      cmd_valid = v; cmd_op = op; cmd_cid = cid; cmd_arg = a;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd7;
   endtask

   initial begin
      #4000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 powered", 32'(powered), 0);
      chk("R1 pend", 32'(wake_pend), 0);
      chk("R1 standby", 32'(standby), 0);
      chk("R1 wen", 32'(wake_en), 0);
      chk("R1 reason", 32'(wake_reason), 0);
      chk("R1 ack/rst", {27'd0, wake_ack, core_rst}, 0);

      for (int i = 0; i < NV; i++) begin
         cmd(1'b1, VEC[i][18:16], VEC[i][15:14], VEC[i][13]);
         chk($sformatf("R3/R4 ack v%0d", i), 32'(wake_ack), 32'(VEC[i][12]));
         chk($sformatf("R3/R7 rst v%0d", i), 32'(core_rst), 32'(VEC[i][11:8]));
         chk($sformatf("R9 powered v%0d", i), 32'(powered), 32'(VEC[i][7:4]));
         chk($sformatf("R2/R5 pend v%0d", i), 32'(wake_pend), 32'(VEC[i][3:0]));
      end

      // R3 R7 reason codes: c0 irq wake, c1 cold, c2 pon request
      chk("R3 R7 reason", 32'(wake_reason), 32'h21);
      // pulse width: one idle cycle later both pulses drop
      cmd(1'b1, 3'd0, 2'd0, 1'b0);
      cmd(1'b0, 3'd0, 2'd1, 1'b0);
      chk("R3 pulse width", {27'd0, wake_ack, core_rst}, 0);
      // R10 valid low ignored
      chk("R10 valid low pend", 32'(wake_pend), 32'h1);
      // R8 standby and wen
      cmd(1'b1, 3'd2, 2'd3, 1'b0);
      chk("R8 standby set", 32'(standby), 32'h8);
      cmd(1'b1, 3'd2, 2'd1, 1'b0);
      cmd(1'b1, 3'd3, 2'd1, 1'b0);
      chk("R8 standby clr", 32'(standby), 32'h8);
      // R7 start clears standby
      cmd(1'b1, 3'd0, 2'd3, 1'b0);
      chk("R2 c3 pend", 32'(wake_pend), 32'h9);
      cmd(1'b1, 3'd5, 2'd3, 1'b0);
      chk("R7 standby cleared", 32'(standby), 0);
      chk("R7 pend cleared", 32'(wake_pend), 32'h1);
      chk("R7 c3 powered", 32'(powered), 32'hd);
      chk("R7 c3 reason", 32'(wake_reason[7:6]), 0);
      // R4 wen 0 blocks power-on
      cmd(1'b1, 3'd4, 2'd0, 1'b0);
      chk("R8 wen write 0", 32'(wake_en), 0);
      cmd(1'b1, 3'd6, 2'd0, 1'b0);
      cmd(1'b1, 3'd0, 2'd0, 1'b0);
      chk("R4 no ack wen 0", {27'd0, wake_ack, core_rst}, 0);
      chk("R4 stays off", 32'(powered), 32'hc);
      chk("R2 pend set", 32'(wake_pend), 32'h1);
      chk("R6 reason kept", 32'(wake_reason[1:0]), 32'h1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule